// File: doc/BRIEF.md
# Dual-Channel I/Q Proportional-Integral Field Regulator

This block closes a fast regulation loop on an RF cavity field given as baseband in-phase (I) and quadrature (Q) samples. For every accepted sample it takes the measured I and Q away from their programmable targets. Each of the two differences feeds its own controller, made only of a proportional path and a saturating integral path. A per-sample feed-forward value is added to each controller's result. The sum is clamped to the signed converter range and sent on to the modulator as the drive pair.

Samples come in on a valid/ready stream and leave on another. The pipeline is three registers deep and moves as one piece. It advances whenever its last stage is empty or that stage is being taken this cycle, so `in_ready` is `!out_valid || out_ready`, and it depends combinationally on `out_ready`. An input is taken only on a cycle where `in_valid` and `in_ready` are both high. A result that is offered and not taken stays unchanged on the output until it is accepted. The target, gain, shift, feed-forward and enable inputs are all sampled on the cycle the measurement is accepted, and they travel along with it. When the loop is switched off, the drive equals the feed-forward value and the integrators keep their contents.

Top module: `iq_pi_loop`

## Requirements
- R1: Each channel's error is its target minus its measurement, worked out in DW+1 bits. The I result depends only on the I-side inputs and the Q result only on the Q-side inputs, with gains, shifts and enable shared between them.
- R2: The proportional term is (error × p_gain) arithmetically shifted right by p_shift, both gain and error taken as signed, and then saturated to the AW-bit signed range.
- R3: For each enabled sample, the integrator adds (error × i_gain) arithmetically shifted right by i_shift, saturated to AW bits. The sum is saturated at the AW-bit signed limits and never wraps.
- R4: With the loop enabled, the drive is proportional term + updated integrator + feed-forward, clamped to the DW-bit signed range [-2^(DW-1), 2^(DW-1)-1].
- R5: With the loop disabled for a sample, that sample's drive equals its feed-forward value, and neither integrator changes.
- R6: Reset (rst_n low, asynchronous) clears both integrators and empties the pipeline: out_valid is 0 and in_ready is 1.
- R7: With out_ready held high, a sample accepted at one clock edge shows up with out_valid high after the third edge counting that one. Results come out in acceptance order.
- R8: in_ready equals !out_valid || out_ready. While out_valid is high and out_ready is low, the drive pair and out_valid stay unchanged and no input is taken.
- R9: Targets, gains, shifts, feed-forward and enable are sampled together with the measurement when it is accepted. Later changes do not affect samples already in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Measurement sample offered |
| in_ready | output | 1 | Block will take the offered sample |
| meas_i | input | DW | Measured I, signed |
| meas_q | input | DW | Measured Q, signed |
| tgt_i | input | DW | I target, signed |
| tgt_q | input | DW | Q target, signed |
| ff_i | input | DW | I feed-forward, signed |
| ff_q | input | DW | Q feed-forward, signed |
| p_gain | input | GW | Proportional gain, signed |
| i_gain | input | GW | Integral gain, signed |
| p_shift | input | SW | Right shift after proportional multiply |
| i_shift | input | SW | Right shift after integral multiply |
| loop_en | input | 1 | Feedback enabled for this sample |
| out_valid | output | 1 | Drive pair offered |
| out_ready | input | 1 | Downstream takes the drive pair |
| drive_i | output | DW | I drive to modulator, signed |
| drive_q | output | DW | Q drive to modulator, signed |

## Verification
The bench pushes an integrator past its positive limit and then reverses the error. A design that wraps would swing the drive to a large negative value at once, where the correct design recovers step by step from the clamp. It switches the loop off mid-stream and then back on with zero gains and zero feed-forward, so the held integrator shows up on the drive; a design that kept integrating, or that cleared on disable, would show a different level. Random back-pressure together with control inputs that change every cycle would catch a design that drops or repeats results when stalled, or that reads gains and targets late.

// File: rtl/iqpi_pkg.sv
package iqpi_pkg;

  typedef enum int {
    CH_I = 0,
    CH_Q = 1
  } iqpi_chan_e;

  localparam int IQPI_NCH = 2;

  // Clamp a wide signed value into the signed range of a w-bit word.
  function automatic logic signed [63:0] iqpi_sat(input logic signed [63:0] v,
                                                  input int unsigned w);
    logic signed [63:0] hi;
    logic signed [63:0] lo;
    hi = (64'sd1 <<< (w - 1)) - 64'sd1;
    lo = -(64'sd1 <<< (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

endpackage

// File: rtl/iqpi_flow.sv
module iqpi_flow (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic adv,
  output logic v1,
  output logic out_valid
);

  logic v1_q, v2_q, v3_q;

  // whole pipeline moves when the last slot is free or being drained
  assign adv       = !v3_q || out_ready;
  assign in_ready  = adv;
  assign v1        = v1_q;
  assign out_valid = v3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
      v3_q <= 1'b0;
    end else if (adv) begin
      v1_q <= in_valid;
      v2_q <= v1_q;
      v3_q <= v2_q;
    end
  end

endmodule

// File: rtl/iqpi_channel.sv
module iqpi_channel
  import iqpi_pkg::*;
#(
  parameter int DW = 16,
  parameter int GW = 16,
  parameter int SW = 4,
  parameter int AW = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic                 v1,
  input  logic                 en1,
  input  logic                 en2,
  input  logic signed [DW-1:0] tgt,
  input  logic signed [DW-1:0] meas,
  input  logic signed [DW-1:0] ff,
  input  logic signed [GW-1:0] kp1,
  input  logic signed [GW-1:0] ki1,
  input  logic        [SW-1:0] psh1,
  input  logic        [SW-1:0] ish1,
  output logic signed [DW-1:0] drive,
  output logic signed [AW-1:0] acc
);

  localparam int EW = DW + 1;
  localparam int PW = EW + GW;

  logic signed [EW-1:0] err1;
  logic signed [DW-1:0] ff1, ff2;
  logic signed [AW-1:0] p2;
  logic signed [PW-1:0] prod_p, prod_i;
  logic signed [63:0]   p_sh, i_sh, acc_sum, out_sum;

  always_comb begin
    prod_p  = err1 * kp1;
    prod_i  = err1 * ki1;
    p_sh    = 64'(prod_p >>> psh1);
    i_sh    = 64'(prod_i >>> ish1);
    acc_sum = 64'(acc) + iqpi_sat(i_sh, AW);
    out_sum = 64'(p2) + 64'(acc) + 64'(ff2);
  end

  // stage 1: error and feed-forward capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err1 <= '0;
      ff1  <= '0;
    end else if (adv) begin
      err1 <= EW'(tgt) - EW'(meas);
      ff1  <= ff;
    end
  end

  // stage 2: proportional term and integrator update
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p2  <= '0;
      acc <= '0;
      ff2 <= '0;
    end else if (adv) begin
      p2  <= AW'(iqpi_sat(p_sh, AW));
      ff2 <= ff1;
      if (v1 && en1) acc <= AW'(iqpi_sat(acc_sum, AW));
    end
  end

  // stage 3: sum and converter clamp
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive <= '0;
    end else if (adv) begin
      drive <= en2 ? DW'(iqpi_sat(out_sum, DW)) : ff2;
    end
  end

endmodule

// File: rtl/iq_pi_loop.sv
module iq_pi_loop
  import iqpi_pkg::*;
#(
  parameter int DW = 16,
  parameter int GW = 16,
  parameter int SW = 4,
  parameter int AW = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] meas_i,
  input  logic signed [DW-1:0] meas_q,
  input  logic signed [DW-1:0] tgt_i,
  input  logic signed [DW-1:0] tgt_q,
  input  logic signed [DW-1:0] ff_i,
  input  logic signed [DW-1:0] ff_q,
  input  logic signed [GW-1:0] p_gain,
  input  logic signed [GW-1:0] i_gain,
  input  logic        [SW-1:0] p_shift,
  input  logic        [SW-1:0] i_shift,
  input  logic                 loop_en,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [DW-1:0] drive_i,
  output logic signed [DW-1:0] drive_q
);

  logic adv, v1;
  logic signed [GW-1:0] kp1, ki1;
  logic        [SW-1:0] psh1, ish1;
  logic                 en1, en2;

  logic signed [DW-1:0] tgt_a  [IQPI_NCH];
  logic signed [DW-1:0] meas_a [IQPI_NCH];
  logic signed [DW-1:0] ff_a   [IQPI_NCH];
  logic signed [DW-1:0] drv_a  [IQPI_NCH];
  logic signed [AW-1:0] acc_a  [IQPI_NCH];
  logic signed [AW-1:0] acc_i_w, acc_q_w;

  assign tgt_a[CH_I]  = tgt_i;
  assign tgt_a[CH_Q]  = tgt_q;
  assign meas_a[CH_I] = meas_i;
  assign meas_a[CH_Q] = meas_q;
  assign ff_a[CH_I]   = ff_i;
  assign ff_a[CH_Q]   = ff_q;
  assign drive_i      = drv_a[CH_I];
  assign drive_q      = drv_a[CH_Q];
  assign acc_i_w      = acc_a[CH_I];
  assign acc_q_w      = acc_a[CH_Q];

  iqpi_flow u_flow (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .adv       (adv),
    .v1        (v1),
    .out_valid (out_valid)
  );

  // shared controls travel with the sample
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kp1  <= '0;
      ki1  <= '0;
      psh1 <= '0;
      ish1 <= '0;
      en1  <= 1'b0;
      en2  <= 1'b0;
    end else if (adv) begin
      kp1  <= p_gain;
      ki1  <= i_gain;
      psh1 <= p_shift;
      ish1 <= i_shift;
      en1  <= loop_en;
      en2  <= en1;
    end
  end

  for (genvar c = 0; c < IQPI_NCH; c++) begin : g_ch
    iqpi_channel #(.DW(DW), .GW(GW), .SW(SW), .AW(AW)) u_ch (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (adv),
      .v1    (v1),
      .en1   (en1),
      .en2   (en2),
      .tgt   (tgt_a[c]),
      .meas  (meas_a[c]),
      .ff    (ff_a[c]),
      .kp1   (kp1),
      .ki1   (ki1),
      .psh1  (psh1),
      .ish1  (ish1),
      .drive (drv_a[c]),
      .acc   (acc_a[c])
    );
  end

endmodule

// File: rtl/iqpi_checker.sv
module iqpi_checker #(
  parameter int DW = 16,
  parameter int AW = 20
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic                 adv,
  input logic                 v1,
  input logic signed [DW-1:0] drive_i,
  input logic signed [DW-1:0] drive_q,
  input logic signed [AW-1:0] acc_i,
  input logic signed [AW-1:0] acc_q
);

  localparam logic signed [AW-1:0] AMAX = {1'b0, {(AW-1){1'b1}}};
  localparam logic signed [AW-1:0] AMIN = {1'b1, {(AW-1){1'b0}}};

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(drive_i) && $stable(drive_q)));

  p_ready_rule_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (!out_valid || out_ready));

  p_acc_i_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(adv && v1) |=> $stable(acc_i));

  p_acc_q_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(adv && v1) |=> $stable(acc_q));

  p_no_wrap_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_i == AMAX) |=> (acc_i != AMIN));

  p_no_wrap_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_i == AMIN) |=> (acc_i != AMAX));

endmodule

bind iq_pi_loop iqpi_checker #(.DW(DW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .adv       (adv),
  .v1        (v1),
  .drive_i   (drive_i),
  .drive_q   (drive_q),
  .acc_i     (acc_i_w),
  .acc_q     (acc_q_w)
);

// File: tb/tb_iq_pi_loop.sv
module tb_iq_pi_loop;
  localparam int DW = 16;
  localparam int GW = 16;
  localparam int SW = 4;
  localparam int AW = 20;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, in_valid, in_ready, loop_en, out_valid, out_ready;
  logic signed [DW-1:0] meas_i, meas_q, tgt_i, tgt_q, ff_i, ff_q, drive_i, drive_q;
  logic signed [GW-1:0] p_gain, i_gain;
  logic [SW-1:0] p_shift, i_shift;

  iq_pi_loop #(.DW(DW), .GW(GW), .SW(SW), .AW(AW)) dut (.*);

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  string req = "R6";

  // behavioural model: integrators and a three-slot delay line of results
  longint m_acc [2];
  bit     m_v   [3];
  longint m_d   [3][2];

  function automatic longint satw(longint v, int w);
    longint hi = (64'sd1 <<< (w - 1)) - 1;
    longint lo = -(64'sd1 <<< (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic longint compute(int c, longint t, longint m, longint f);
    longint e = t - m;
    longint pt = satw((e * longint'(p_gain)) >>> p_shift, AW);
    longint it = satw((e * longint'(i_gain)) >>> i_shift, AW);
    if (loop_en) m_acc[c] = satw(m_acc[c] + it, AW);
    return loop_en ? satw(pt + m_acc[c] + f, DW) : f;
  endfunction

  task automatic check(string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // inputs were driven at this falling edge; compare, then advance the model
  task automatic cyc();
    bit a;
    #1;
    check("in_ready", longint'(in_ready), longint'(!m_v[2] || out_ready));
    check("out_valid", longint'(out_valid), longint'(m_v[2]));
    if (m_v[2]) begin
      check("drive_i", longint'(drive_i), m_d[2][0]);
      check("drive_q", longint'(drive_q), m_d[2][1]);
    end
    if (!rst_n) begin
      m_acc[0] = 0; m_acc[1] = 0;
      for (int k = 0; k < 3; k++) m_v[k] = 0;
    end else begin
      a = !m_v[2] || out_ready;
      if (a) begin
        m_v[2] = m_v[1]; m_d[2] = m_d[1];
        m_v[1] = m_v[0]; m_d[1] = m_d[0];
        m_v[0] = in_valid;
        if (in_valid) begin
          m_d[0][0] = compute(0, tgt_i, meas_i, ff_i);
          m_d[0][1] = compute(1, tgt_q, meas_q, ff_q);
        end
      end
    end
    @(negedge clk);
  endtask

  task automatic put(logic v, int ti, int mi, int fi, int tq, int mq, int fq);
    in_valid = v;
    tgt_i = DW'(ti); meas_i = DW'(mi); ff_i = DW'(fi);
    tgt_q = DW'(tq); meas_q = DW'(mq); ff_q = DW'(fq);
    cyc();
  endtask

  task automatic gains(int kp, int ps, int ki, int is, logic en);
    p_gain = GW'(kp); p_shift = SW'(ps); i_gain = GW'(ki); i_shift = SW'(is); loop_en = en;
  endtask

  task automatic drain();
    in_valid = 0; out_ready = 1;
    for (int k = 0; k < 4; k++) cyc();
  endtask

  function automatic int r16();
    return int'($signed(16'($urandom)));
  endfunction

  initial begin
    rst_n = 0; in_valid = 0; out_ready = 1;
    put(0, 0, 0, 0, 0, 0, 0);
    gains(0, 0, 0, 0, 0);
    @(negedge clk);
    req = "R6";
    cyc(); cyc();
    rst_n = 1;
    cyc();

    // R1 R2 R7: proportional only, unity gain in Q4.12, I and Q distinct
    req = "R2";
    gains(4096, 12, 0, 0, 1);
    for (int k = 0; k < 10; k++) put(1, r16() / 4, r16() / 4, r16() / 8, 100 * k, -50 * k, 7);
    req = "R7";
    drain();
    req = "R1";
    gains(-3000, 10, 0, 0, 1);
    for (int k = 0; k < 6; k++) put(1, 1000, 900 + k, 0, -2000, 0, 10);
    drain();

    // R3: integral accumulation
    req = "R3";
    gains(0, 0, 3, 2, 1);
    for (int k = 0; k < 12; k++) put(1, 400, k * 30, 0, -600, 20, 0);
    drain();

    // R3: drive the integrator into its limit, then reverse
    gains(0, 0, 32767, 0, 1);
    for (int k = 0; k < 5; k++) put(1, 32767, -32768, 0, -32768, 32767, 0);
    gains(0, 0, 1, 0, 1);
    for (int k = 0; k < 14; k++) put(1, -32768, 32767, 0, 32767, -32768, 0);
    drain();

    // R4: output clamp both ways
    req = "R4";
    gains(32767, 0, 0, 0, 1);
    for (int k = 0; k < 6; k++) put(1, 20000 - 8000 * k, 0, 1000, -20000 + 8000 * k, 0, -1000);
    drain();

    // R6: reset mid-run clears integrators
    req = "R6";
    rst_n = 0; cyc(); rst_n = 1; cyc();
    gains(0, 0, 0, 0, 1);
    put(1, 0, 0, 0, 0, 0, 0);
    drain();

    // R5: disable holds integrator and passes feed-forward
    req = "R5";
    gains(0, 0, 1, 4, 1);
    for (int k = 0; k < 5; k++) put(1, 320 + k, 0, 0, -480, k, 0);
    gains(2000, 3, 500, 1, 0);
    for (int k = 0; k < 8; k++) put(1, r16(), r16(), r16(), r16(), r16(), r16());
    gains(0, 0, 0, 0, 1);
    for (int k = 0; k < 3; k++) put(1, 5, 9, 0, -5, 9, 0);
    drain();

    // R8 R9: random back-pressure with controls changing every cycle
    req = "R8";
    for (int k = 0; k < 400; k++) begin
      out_ready = $urandom_range(0, 3) != 0;
      gains(r16(), $urandom_range(0, 15), r16() / 64, $urandom_range(4, 15), $urandom_range(0, 4) != 0);
      put($urandom_range(0, 2) != 0, r16(), r16(), r16() / 2, r16(), r16(), r16() / 2);
      if (k == 200) req = "R9";
    end
    drain();

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule